// File: doc/BRIEF.md
# Strided Vector Load Engine over Interleaved Banks

This block fetches a run of 64-bit elements from an interleaved, multi-bank memory model and places them in a vector register array. A load starts with a one-cycle start pulse. The pulse carries a base byte address, a byte stride, an element count and an operation-type bit. The operation-type bit selects the contiguous (unit-stride) variant or the general strided variant. From the next clock edge the engine sends at most one element request per cycle, in element order. Each bank holds a busy countdown after it accepts a request. When the next element maps to a bank that is still counting down, the engine raises its stall output and waits. Requests are never reordered.

Each accepted request returns its data a fixed number of cycles later, through a shared delay line. The data is written into the vector register at the next element index. A done pulse follows the last write. A cycle counter measures the run from the start pulse to the last write and then holds, so the cost of a stride can be read off directly. The controller has three states. IDLE moves to ISSUE on a start pulse (transition START). ISSUE moves to DRAIN once the final element request is accepted (transition LAST_ISSUE). DRAIN returns to IDLE at the edge that writes the final element (transition LAST_WRITE).

Top module: `vld_strided_load`

## Requirements
- R1: After reset, done and stall are 0, cyc_cnt is 0, the engine is idle, and every vector register element reads 0.
- R2: Element i is fetched from byte address base + i*step, computed modulo 2^32. step is the stride input when op_unit=0. When op_unit=1, step is fixed at 8 bytes and the stride input has no effect.
- R3: The bank of an address is byte-address bits [5:3]. A bank that accepts a request at edge k accepts no other request before edge k+6.
- R4: Requests go out in element order, at most one per edge. The first request can go out at the edge after the start pulse. stall is 1 exactly in those cycles where the next pending element is held because its bank is busy.
- R5: The data word for byte address A is {~X, X}, where X is A with bits [2:0] cleared. A request accepted at edge k is written to the vector register at edge k+12. Element i is placed at index i, and rd_data shows the element selected by rd_idx combinationally.
- R6: cyc_cnt is cleared by the start pulse and increments on every edge up to and including the edge that writes the final element. After that it holds. done is high for exactly the one cycle that follows that edge. A 64-element load totals 76 cycles with op_unit=1 or with a stride of 8. It totals 391 cycles with a stride of 256 bytes.
- R7: len gives the element count. A value of 0, or any value above 64, loads 64 elements.
- R8: A start pulse that arrives while a load is running is ignored. It changes neither the timing nor the addresses of the running load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| start | input | 1 | One-cycle request to begin a load |
| op_unit | input | 1 | 1 selects unit-stride mode (8-byte step) |
| base | input | 32 | Byte address of element 0 |
| stride | input | 32 | Byte step between elements in strided mode |
| len | input | 7 | Element count (0 or >64 means 64) |
| rd_idx | input | 6 | Vector register element to read |
| rd_data | output | 64 | Selected vector register element |
| done | output | 1 | One-cycle pulse after the final write |
| stall | output | 1 | Next request is held on a busy bank |
| cyc_cnt | output | 16 | Cycles from start to final write, then held |

## Verification
Assertions check the following on every cycle:
- No bank is handed a request while its countdown is running.
- done never lasts two cycles.
- The cycle counter stays still while idle.
- A stalled cycle leaves the issue position unchanged.
- Returned data never arrives outside a running load.

Some behaviours can only be shown by the bench's scenarios, each against a reference model that predicts stall, done and cyc_cnt on every clock. These are the exact totals for unit, contiguous, conflicting, partially conflicting, large and negative strides. They also include the fetched words at every index, the handling of the length field, and the rejection of a second start pulse during a load.

// File: rtl/vld_pkg.sv
package vld_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 2 * ADDR_W;
    localparam int ELEM_BYTES = 8;
    localparam int OFS_W      = $clog2(ELEM_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DRAIN
    } ld_state_t;

    // Behavioural memory content: a word is a function of its aligned address.
    function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] al;
        al = a;
        al[OFS_W-1:0] = '0;
        return {~al, al};
    endfunction
endpackage

// File: rtl/vld_bank.sv
module vld_bank
    import vld_pkg::*;
#(
    parameter int BUSY_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic [ADDR_W-1:0] addr,
    output logic              ready,
    output logic              rvld,
    output logic [DATA_W-1:0] rdata
);
    localparam int TMR_W = (BUSY_CYC > 2) ? $clog2(BUSY_CYC) : 1;

    logic [TMR_W-1:0] tmr_q;

    assign ready = (tmr_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
            rvld  <= 1'b0;
        end else begin
            rvld <= acc;
            if (acc)
                tmr_q <= TMR_W'(BUSY_CYC - 1);
            else if (tmr_q != '0)
                tmr_q <= tmr_q - TMR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (acc)
            rdata <= mem_word(addr);
    end

    // R3
    bank_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> (tmr_q == '0));
endmodule

// File: rtl/vld_ret_pipe.sv
module vld_ret_pipe #(
    parameter int DEPTH = 11,
    parameter int W     = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_v,
    input  logic [W-1:0] in_d,
    output logic         out_v,
    output logic [W-1:0] out_d
);
    logic [DEPTH-1:0] v_q;
    logic [W-1:0]     d_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
        end else begin
            v_q[0] <= in_v;
            for (int s = 1; s < DEPTH; s++)
                v_q[s] <= v_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        d_q[0] <= in_d;
        for (int s = 1; s < DEPTH; s++)
            d_q[s] <= d_q[s-1];
    end

    assign out_v = v_q[DEPTH-1];
    assign out_d = d_q[DEPTH-1];
endmodule

// File: rtl/vld_vreg.sv
module vld_vreg #(
    parameter int DEPTH = 64,
    parameter int W     = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] widx,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] ridx,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++)
                mem[e] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/vld_strided_load.sv
module vld_strided_load
    import vld_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BUSY_CYC  = 6,
    parameter int LAT_CYC   = 12,
    parameter int VLEN      = 64,
    parameter int CNT_W     = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      op_unit,
    input  logic [ADDR_W-1:0]         base,
    input  logic [ADDR_W-1:0]         stride,
    input  logic [$clog2(VLEN+1)-1:0] len,
    input  logic [$clog2(VLEN)-1:0]   rd_idx,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      done,
    output logic                      stall,
    output logic [CNT_W-1:0]          cyc_cnt
);
    localparam int LEN_W  = $clog2(VLEN + 1);
    localparam int IDX_W  = $clog2(VLEN);
    localparam int BANK_W = $clog2(NUM_BANKS);

    ld_state_t         state, nxt_state;
    logic [ADDR_W-1:0] cur_addr, step;
    logic [LEN_W-1:0]  iss_cnt, wr_cnt, tgt_len;
    logic [CNT_W-1:0]  cyc_q;
    logic              done_q;

    logic [BANK_W-1:0]    tgt_bank;
    logic [NUM_BANKS-1:0] bank_rdy, bank_acc, bk_rvld;
    logic [DATA_W-1:0]    bk_rdata [NUM_BANKS];
    logic                 issue_fire, last_iss, last_wr;
    logic                 mrg_v, ret_v;
    logic [DATA_W-1:0]    mrg_d, ret_d;

    assign tgt_bank   = cur_addr[OFS_W +: BANK_W];
    assign issue_fire = (state == ST_ISSUE) && bank_rdy[tgt_bank];
    assign last_iss   = issue_fire && (iss_cnt == tgt_len - LEN_W'(1));
    assign last_wr    = ret_v && (wr_cnt == tgt_len - LEN_W'(1));

    always_comb begin
        bank_acc = '0;
        bank_acc[tgt_bank] = issue_fire;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        vld_bank #(.BUSY_CYC(BUSY_CYC)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .acc   (bank_acc[b]),
            .addr  (cur_addr),
            .ready (bank_rdy[b]),
            .rvld  (bk_rvld[b]),
            .rdata (bk_rdata[b])
        );
    end

    always_comb begin
        mrg_v = |bk_rvld;
        mrg_d = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (bk_rvld[b])
                mrg_d = mrg_d | bk_rdata[b];
    end

    vld_ret_pipe #(.DEPTH(LAT_CYC - 1), .W(DATA_W)) u_ret (
        .clk   (clk),
        .rst_n (rst_n),
        .in_v  (mrg_v),
        .in_d  (mrg_d),
        .out_v (ret_v),
        .out_d (ret_d)
    );

    vld_vreg #(.DEPTH(VLEN), .W(DATA_W)) u_vreg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ret_v),
        .widx  (wr_cnt[IDX_W-1:0]),
        .wdata (ret_d),
        .ridx  (rd_idx),
        .rdata (rd_data)
    );

    // Next-state logic
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE:  if (start)    nxt_state = ST_ISSUE;
            ST_ISSUE: if (last_iss) nxt_state = ST_DRAIN;
            ST_DRAIN: if (last_wr)  nxt_state = ST_IDLE;
            default:                nxt_state = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // Datapath and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            step     <= '0;
            iss_cnt  <= '0;
            wr_cnt   <= '0;
            tgt_len  <= LEN_W'(VLEN);
            cyc_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state == ST_IDLE && start) begin
                cur_addr <= base;
                step     <= op_unit ? ADDR_W'(ELEM_BYTES) : stride;
                tgt_len  <= (len == '0 || len > LEN_W'(VLEN)) ? LEN_W'(VLEN) : len;
                iss_cnt  <= '0;
                wr_cnt   <= '0;
                cyc_q    <= '0;
            end else if (state != ST_IDLE) begin
                cyc_q <= cyc_q + CNT_W'(1);
                if (issue_fire) begin
                    cur_addr <= cur_addr + step;
                    iss_cnt  <= iss_cnt + LEN_W'(1);
                end
                if (ret_v)
                    wr_cnt <= wr_cnt + LEN_W'(1);
                if (last_wr)
                    done_q <= 1'b1;
            end
        end
    end

    // Output process
    always_comb begin
        stall   = (state == ST_ISSUE) && !bank_rdy[tgt_bank];
        done    = done_q;
        cyc_cnt = cyc_q;
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> $stable(cyc_cnt));

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(iss_cnt) && $stable(cur_addr)));

    // R5
    ret_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_v |-> (state != ST_IDLE));
endmodule

// File: tb/vld_strided_load_tb_top.sv
module vld_strided_load_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_unit = 1'b0;
    logic [31:0] base = '0;
    logic [31:0] stride = '0;
    logic [6:0]  len = '0;
    logic [5:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic        done, stall;
    logic [15:0] cyc_cnt;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    vld_strided_load dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_unit(op_unit),
        .base(base), .stride(stride), .len(len), .rd_idx(rd_idx),
        .rd_data(rd_data), .done(done), .stall(stall), .cyc_cnt(cyc_cnt)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_word(input logic [31:0] a);
        logic [31:0] al;
        al = {a[31:3], 3'b000};
        return {~al, al};
    endfunction

    // Reference model: predicts per-cycle stall, done and counter, then the register content.
    task automatic run_load(input bit unit, input logic [31:0] b, input logic [31:0] s,
                            input int n_in, input bit poke, input int exp_total);
        int n, t, t_prev, tot, bk;
        int free_at [8];
        bit exp_stall [1024];
        logic [31:0] st;
        n  = (n_in == 0 || n_in > 64) ? 64 : n_in;
        st = unit ? 32'd8 : s;
        foreach (free_at[k]) free_at[k] = 0;
        foreach (exp_stall[k]) exp_stall[k] = 1'b0;
        t_prev = 0;
        for (int j = 0; j < n; j++) begin
            logic [31:0] ea;
            ea = b + 32'(j) * st;
            bk = int'(ea[5:3]);
            t  = (t_prev + 1 > free_at[bk]) ? t_prev + 1 : free_at[bk];
            for (int c = t_prev + 1; c < t; c++) exp_stall[c] = 1'b1;
            free_at[bk] = t + 6;
            t_prev = t;
        end
        tot = t_prev + 12;

        @(negedge clk);
        start = 1'b1; op_unit = unit; base = b; stride = s; len = 7'(n_in);
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= tot + 1; c++) begin
            chk(stall == exp_stall[c], "R4 stall per cycle", 64'(stall), 64'(exp_stall[c]));
            chk(cyc_cnt == 16'(c - 1), "R6 cycle counter", 64'(cyc_cnt), 64'(c - 1));
            chk(done == (c - 1 == tot), "R6 done pulse", 64'(done), 64'(c - 1 == tot));
            if (poke && c == 5) begin
                start = 1'b1; op_unit = 1'b0; base = 32'h5555_0000; stride = 32'd24; len = 7'd3;
            end
            if (poke && c == 6) start = 1'b0;
            @(negedge clk);
        end
        chk(done == 1'b0, "R6 done single cycle", 64'(done), 64'd0);
        chk(cyc_cnt == 16'(tot), "R6 counter holds", 64'(cyc_cnt), 64'(tot));
        if (exp_total > 0)
            chk(cyc_cnt == 16'(exp_total), "R6 known total", 64'(cyc_cnt), 64'(exp_total));
        for (int i = 0; i < n; i++) begin
            logic [63:0] ew;
            ew = exp_word(b + 32'(i) * st);
            rd_idx = 6'(i);
            #1;
            chk(rd_data == ew, poke ? "R8 data after ignored start" : "R2 R5 element data", rd_data, ew);
        end
        rd_idx = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
        chk(stall == 1'b0, "R1 stall", 64'(stall), 64'd0);
        chk(cyc_cnt == 16'd0, "R1 counter", 64'(cyc_cnt), 64'd0);
        rd_idx = 6'd17; #1;
        chk(rd_data == 64'd0, "R1 register cleared", rd_data, 64'd0);
        rd_idx = '0;

        // R2 unit mode ignores stride; R7 len 0 means 64; R6 76-cycle total
        run_load(1'b1, 32'h0000_1000, 32'hDEAD_BEEF, 0, 1'b0, 76);
        // R6 contiguous strided variant also 76
        run_load(1'b0, 32'h0000_0200, 32'd8, 64, 1'b0, 76);
        // R3 same-bank stride gives 391
        run_load(1'b0, 32'h0000_0040, 32'd256, 64, 1'b0, 391);
        // R3 R4 two-word stride cycles four banks, stalls
        run_load(1'b0, 32'h0000_0008, 32'd16, 20, 1'b0, 0);
        // R8 start ignored mid-run, wide stride
        run_load(1'b0, 32'h2000_0000, 32'd800, 64, 1'b1, 0);
        // R2 negative stride wraps
        run_load(1'b0, 32'h0000_0100, 32'hFFFF_FFF8, 64, 1'b0, 0);
        // R7 short length and oversize length
        run_load(1'b0, 32'h0000_0018, 32'd24, 1, 1'b0, 13);
        run_load(1'b0, 32'h0000_0300, 32'd64, 100, 1'b0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule